// File: doc/BRIEF.md
# Register Rename Map with Rollback History

This block turns architectural register numbers into physical register numbers for an out-of-order core. It keeps a mapping table, a ready bit per physical register, a queue of free physical registers and an ordered history of every destination rename. A rename request reads up to two source mappings together with their ready bits and, when it has a destination, takes a fresh physical register from the free queue, points the architectural register at it and logs the change.

The same history queue serves recovery in both directions. A squash walks it from the youngest entry backwards, putting each previous mapping back and handing the speculative register back to the free queue. A commit walks it from the oldest entry forwards, releasing the registers that the committed instructions made obsolete. Both walks retire one history entry per clock and raise a busy flag that holds off new renames.

Physical registers with an index at or above the main register count are side registers; when a squash frees one, its ready bit is set again.

Top module: `rename_rollback_map`

## Requirements
- R1: After reset, architectural register i maps to physical register i, every mapped register reads ready, `busy` is low, and the free queue hands out physical registers NUM_ARCH up to NUM_PHYS-1 in ascending order.
- R2: Each source port returns the physical register currently mapped to its architectural input and that register's ready bit; the lookup sees the mapping as it stood before the same request's destination rename.
- R3: An accepted request with `renDestValid`=1 is given the register at the head of the free queue on `renDestPhys`; from the next cycle the destination maps to it and it reads not ready.
- R4: A request with `renDestValid`=1 is refused (`renAccept`=0) while the free queue is empty; a request with `renDestValid`=0 is accepted even then and logs no history.
- R5: `renAccept` is 0 while `busy` is high and in any cycle in which `squashValid` or `commitValid` is high.
- R6: A squash undoes history entries from the youngest end while their sequence number is greater than `squashSeq`, restoring each previous mapping and appending the undone register to the tail of the free queue.
- R7: A commit retires history entries from the oldest end while their sequence number is at most `commitSeq`, appending each entry's previous register to the tail of the free queue.
- R8: A commit retires nothing when `squashValid` is high in the same cycle, while a squash walk is in progress, when the history is empty, or when the oldest entry's sequence number is above `commitSeq`.
- R9: After a squash or commit request, `busy` is high from the next cycle for exactly k+1 cycles, where k is the number of entries undone or retired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| renValid | input | 1 | Rename request present |
| renSeq | input | SEQ_W | Sequence number of the requesting instruction |
| renDestValid | input | 1 | Request carries one destination register |
| renDestArch | input | AW | Destination architectural register |
| renSrcA | input | AW | First source architectural register |
| renSrcB | input | AW | Second source architectural register |
| squashValid | input | 1 | Squash request |
| squashSeq | input | SEQ_W | Youngest sequence number that survives the squash |
| commitValid | input | 1 | Commit request |
| commitSeq | input | SEQ_W | Youngest committed sequence number |
| renAccept | output | 1 | Rename request taken this cycle |
| renDestPhys | output | PW | Physical register given to the destination |
| srcPhysA | output | PW | Mapping of the first source |
| srcReadyA | output | 1 | Ready bit of the first source mapping |
| srcPhysB | output | PW | Mapping of the second source |
| srcReadyB | output | 1 | Ready bit of the second source mapping |
| busy | output | 1 | A squash or commit walk is running |

## Verification
A squash and a commit may be requested in the same clock; the bench raises both together with a commit number high enough to retire the whole history and a squash number that removes the three youngest renames. The squash must win: the youngest mappings roll back, and the commit must leave no trace, which the bench judges by the number of renames accepted afterwards being exactly the three registers the squash returned. A rename offered during the walk is also checked to be refused.

// File: rtl/rmh_pkg.sv
package rmh_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SQUASH,
    ST_COMMIT
  } rmhState_e;

  typedef struct packed {
    logic doRename;
    logic doUndo;
    logic doRetire;
  } rmhStrobe_t;

endpackage

// File: rtl/rmh_ctrl.sv
module rmh_ctrl
  import rmh_pkg::*;
#(
  parameter int SEQ_W = 8,
  parameter int CW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             renValid,
  input  logic             renDestValid,
  input  logic             squashValid,
  input  logic [SEQ_W-1:0] squashSeq,
  input  logic             commitValid,
  input  logic [SEQ_W-1:0] commitSeq,
  input  logic [CW-1:0]    freeCnt,
  input  logic             histEmpty,
  input  logic [SEQ_W-1:0] newestSeq,
  input  logic [SEQ_W-1:0] oldestSeq,
  output rmhStrobe_t       stb,
  output logic             busy
);

  rmhState_e        state;
  logic [SEQ_W-1:0] tgtSeq;
  logic             undoCond, retireCond, anyReq;

  assign anyReq     = squashValid || commitValid;
  assign undoCond   = !histEmpty && (newestSeq > tgtSeq);
  assign retireCond = !histEmpty && (oldestSeq <= tgtSeq);
  assign busy       = (state != ST_IDLE);

  always_comb begin
    stb = '0;
    case (state)
      ST_IDLE:   stb.doRename = renValid && !anyReq &&
                                (!renDestValid || freeCnt != '0);
      ST_SQUASH: stb.doUndo   = !squashValid && undoCond;
      ST_COMMIT: stb.doRetire = !anyReq && retireCond;
      default:   stb = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      tgtSeq <= '0;
    end else if (squashValid) begin
      state  <= ST_SQUASH;
      tgtSeq <= squashSeq;
    end else if (commitValid && state != ST_SQUASH) begin
      state  <= ST_COMMIT;
      tgtSeq <= commitSeq;
    end else begin
      case (state)
        ST_SQUASH: if (!undoCond)   state <= ST_IDLE;
        ST_COMMIT: if (!retireCond) state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rmh_data.sv
module rmh_data
  import rmh_pkg::*;
#(
  parameter int NUM_ARCH = 8,
  parameter int NUM_PHYS = 16,
  parameter int NUM_MAIN = 14,
  parameter int SEQ_W    = 8,
  localparam int AW      = $clog2(NUM_ARCH),
  localparam int PW      = $clog2(NUM_PHYS),
  localparam int DEPTH   = NUM_PHYS - NUM_ARCH,
  localparam int IW      = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW      = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  rmhStrobe_t       stb,
  input  logic [SEQ_W-1:0] renSeq,
  input  logic             renDestValid,
  input  logic [AW-1:0]    renDestArch,
  input  logic [AW-1:0]    renSrcA,
  input  logic [AW-1:0]    renSrcB,
  output logic [PW-1:0]    renDestPhys,
  output logic [PW-1:0]    srcPhysA,
  output logic             srcReadyA,
  output logic [PW-1:0]    srcPhysB,
  output logic             srcReadyB,
  output logic [CW-1:0]    freeCnt,
  output logic [CW-1:0]    histCnt,
  output logic             histEmpty,
  output logic [SEQ_W-1:0] newestSeq,
  output logic [SEQ_W-1:0] oldestSeq
);

  logic [PW-1:0]       mapTab  [NUM_ARCH];
  logic [NUM_PHYS-1:0] readyVec;
  logic [PW-1:0]       freeRam [DEPTH];
  logic [IW-1:0]       fHead, fTail;
  logic [SEQ_W-1:0]    hSeq    [DEPTH];
  logic [AW-1:0]       hArch   [DEPTH];
  logic [PW-1:0]       hNew    [DEPTH];
  logic [PW-1:0]       hPrev   [DEPTH];
  logic [IW-1:0]       hHead, hTail, newestIdx;
  logic                alloc, give;

  function automatic logic [IW-1:0] wrapInc(input logic [IW-1:0] p);
    return (p == IW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign alloc       = stb.doRename && renDestValid;
  assign give        = stb.doUndo || stb.doRetire;
  assign newestIdx   = (hTail == '0) ? IW'(DEPTH - 1) : hTail - 1'b1;
  assign renDestPhys = freeRam[fHead];
  assign srcPhysA    = mapTab[renSrcA];
  assign srcPhysB    = mapTab[renSrcB];
  assign srcReadyA   = readyVec[mapTab[renSrcA]];
  assign srcReadyB   = readyVec[mapTab[renSrcB]];
  assign histEmpty   = (histCnt == '0);
  assign newestSeq   = hSeq[newestIdx];
  assign oldestSeq   = hSeq[hHead];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ARCH; i++) mapTab[i] <= PW'(i);
      for (int i = 0; i < DEPTH; i++) begin
        freeRam[i] <= PW'(NUM_ARCH + i);
        hSeq[i]    <= '0;
        hArch[i]   <= '0;
        hNew[i]    <= '0;
        hPrev[i]   <= '0;
      end
      readyVec <= '1;
      fHead    <= '0;
      fTail    <= '0;
      hHead    <= '0;
      hTail    <= '0;
      freeCnt  <= CW'(DEPTH);
      histCnt  <= '0;
    end else begin
      if (alloc) begin
        mapTab[renDestArch]      <= freeRam[fHead];
        readyVec[freeRam[fHead]] <= 1'b0;
        hSeq[hTail]              <= renSeq;
        hArch[hTail]             <= renDestArch;
        hNew[hTail]              <= freeRam[fHead];
        hPrev[hTail]             <= mapTab[renDestArch];
        hTail                    <= wrapInc(hTail);
        fHead                    <= wrapInc(fHead);
      end
      if (stb.doUndo) begin
        mapTab[hArch[newestIdx]] <= hPrev[newestIdx];
        freeRam[fTail]           <= hNew[newestIdx];
        if ({1'b0, hNew[newestIdx]} >= (PW + 1)'(NUM_MAIN))
          readyVec[hNew[newestIdx]] <= 1'b1;
        fTail <= wrapInc(fTail);
        hTail <= newestIdx;
      end else if (stb.doRetire) begin
        freeRam[fTail] <= hPrev[hHead];
        fTail          <= wrapInc(fTail);
        hHead          <= wrapInc(hHead);
      end
      freeCnt <= freeCnt - CW'(alloc) + CW'(give);
      histCnt <= histCnt + CW'(alloc) - CW'(give);
    end
  end

endmodule

// File: rtl/rename_rollback_map.sv
module rename_rollback_map
  import rmh_pkg::*;
#(
  parameter int NUM_ARCH = 8,
  parameter int NUM_PHYS = 16,
  parameter int NUM_MAIN = 14,
  parameter int SEQ_W    = 8,
  localparam int AW      = $clog2(NUM_ARCH),
  localparam int PW      = $clog2(NUM_PHYS),
  localparam int DEPTH   = NUM_PHYS - NUM_ARCH,
  localparam int CW      = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             renValid,
  input  logic [SEQ_W-1:0] renSeq,
  input  logic             renDestValid,
  input  logic [AW-1:0]    renDestArch,
  input  logic [AW-1:0]    renSrcA,
  input  logic [AW-1:0]    renSrcB,
  input  logic             squashValid,
  input  logic [SEQ_W-1:0] squashSeq,
  input  logic             commitValid,
  input  logic [SEQ_W-1:0] commitSeq,
  output logic             renAccept,
  output logic [PW-1:0]    renDestPhys,
  output logic [PW-1:0]    srcPhysA,
  output logic             srcReadyA,
  output logic [PW-1:0]    srcPhysB,
  output logic             srcReadyB,
  output logic             busy
);

  rmhStrobe_t       stb;
  logic [CW-1:0]    freeCnt, histCnt;
  logic             histEmpty;
  logic [SEQ_W-1:0] newestSeq, oldestSeq;

  assign renAccept = stb.doRename;

  rmh_ctrl #(.SEQ_W(SEQ_W), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .renValid(renValid), .renDestValid(renDestValid),
    .squashValid(squashValid), .squashSeq(squashSeq),
    .commitValid(commitValid), .commitSeq(commitSeq),
    .freeCnt(freeCnt), .histEmpty(histEmpty),
    .newestSeq(newestSeq), .oldestSeq(oldestSeq),
    .stb(stb), .busy(busy)
  );

  rmh_data #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS), .NUM_MAIN(NUM_MAIN),
             .SEQ_W(SEQ_W)) u_data (
    .clk(clk), .rst_n(rst_n), .stb(stb), .renSeq(renSeq),
    .renDestValid(renDestValid), .renDestArch(renDestArch),
    .renSrcA(renSrcA), .renSrcB(renSrcB), .renDestPhys(renDestPhys),
    .srcPhysA(srcPhysA), .srcReadyA(srcReadyA),
    .srcPhysB(srcPhysB), .srcReadyB(srcReadyB),
    .freeCnt(freeCnt), .histCnt(histCnt), .histEmpty(histEmpty),
    .newestSeq(newestSeq), .oldestSeq(oldestSeq)
  );

endmodule

// File: rtl/rmh_checker.sv
module rmh_checker
  import rmh_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          renAccept,
  input logic          renDestValid,
  input logic          squashValid,
  input rmhStrobe_t    stb,
  input logic [CW-1:0] freeCnt,
  input logic [CW-1:0] histCnt
);

  AST_BUSY_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !renAccept); // R5

  AST_NO_EMPTY_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    (renAccept && renDestValid) |-> (freeCnt != '0)); // R4

  AST_POOL_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(freeCnt) + 32'(histCnt)) == DEPTH); // R7

  AST_ALLOC_RECORDS: assert property (@(posedge clk) disable iff (!rst_n)
    (renAccept && renDestValid) |=> (histCnt == $past(histCnt) + 1'b1)); // R3

  AST_UNDO_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    stb.doUndo |=> (histCnt == $past(histCnt) - 1'b1)); // R6

  AST_SQUASH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    squashValid |=> busy); // R9

  AST_SQUASH_BEATS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    squashValid |=> !stb.doRetire); // R8

endmodule

bind rename_rollback_map rmh_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .renAccept(renAccept),
  .renDestValid(renDestValid), .squashValid(squashValid), .stb(stb),
  .freeCnt(freeCnt), .histCnt(histCnt)
);

// File: tb/sim_rename_rollback_map.sv
`timescale 1ns/1ps
module sim_rename_rollback_map;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       renValid = 1'b0;
  logic [7:0] renSeq = '0;
  logic       renDestValid = 1'b0;
  logic [2:0] renDestArch = '0;
  logic [2:0] renSrcA = '0;
  logic [2:0] renSrcB = '0;
  logic       squashValid = 1'b0;
  logic [7:0] squashSeq = '0;
  logic       commitValid = 1'b0;
  logic [7:0] commitSeq = '0;
  logic       renAccept, srcReadyA, srcReadyB, busy;
  logic [3:0] renDestPhys, srcPhysA, srcPhysB;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  rename_rollback_map u0 (
    .clk(clk), .rst_n(rst_n), .renValid(renValid), .renSeq(renSeq),
    .renDestValid(renDestValid), .renDestArch(renDestArch),
    .renSrcA(renSrcA), .renSrcB(renSrcB),
    .squashValid(squashValid), .squashSeq(squashSeq),
    .commitValid(commitValid), .commitSeq(commitSeq),
    .renAccept(renAccept), .renDestPhys(renDestPhys),
    .srcPhysA(srcPhysA), .srcReadyA(srcReadyA),
    .srcPhysB(srcPhysB), .srcReadyB(srcReadyB), .busy(busy)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Lookup only, no request.
  task automatic lookup(input int a, input int b, input int pa, input int ra,
                        input int pb, input int rb, input string req);
    @(negedge clk);
    renSrcA = 3'(a); renSrcB = 3'(b);
    #1;
    check(req, int'(srcPhysA), pa);
    check(req, int'(srcReadyA), ra);
    check(req, int'(srcPhysB), pb);
    check(req, int'(srcReadyB), rb);
  endtask

  task automatic rename(input int seq, input bit hasDest, input int dArch,
                        input int expAcc, input int expDest, input string req);
    @(negedge clk);
    renValid = 1'b1; renSeq = 8'(seq); renDestValid = hasDest;
    renDestArch = 3'(dArch);
    #1;
    check(req, int'(renAccept), expAcc);
    if (expAcc == 1 && hasDest) check(req, int'(renDestPhys), expDest);
    @(posedge clk);
    #1;
    renValid = 1'b0; renDestValid = 1'b0;
  endtask

  // Pulse squash and/or commit, try a rename during the walk, count busy cycles.
  task automatic walk(input bit sq, input int sSeq, input bit cm, input int cSeq,
                      input int expBusy, input string req);
    int n = 0;
    @(negedge clk);
    squashValid = sq; squashSeq = 8'(sSeq);
    commitValid = cm; commitSeq = 8'(cSeq);
    renValid = 1'b1; renDestValid = 1'b0;
    #1;
    check("R5 refuse with request", int'(renAccept), 0);
    renValid = 1'b0;
    @(negedge clk);
    squashValid = 1'b0; commitValid = 1'b0;
    renValid = 1'b1;
    #1;
    check("R5 refuse while busy", int'(renAccept), 0);
    renValid = 1'b0;
    while (busy && n < 50) begin
      n++;
      @(negedge clk);
    end
    check(req, n, expBusy);
  endtask

  task automatic t_reset();
    lookup(3, 7, 3, 1, 7, 1, "R1 reset map");
    check("R1 busy after reset", int'(busy), 0);
  endtask

  task automatic t_basic();
    renSrcA = 3'd1; renSrcB = 3'd2;
    @(negedge clk);
    renValid = 1'b1; renSeq = 8'd10; renDestValid = 1'b1; renDestArch = 3'd1;
    #1;
    check("R2 lookup before dest", int'(srcPhysA), 1);
    check("R2 ready before dest", int'(srcReadyA), 1);
    check("R1 first free reg", int'(renDestPhys), 8);
    @(posedge clk);
    #1;
    renValid = 1'b0; renDestValid = 1'b0;
    lookup(1, 2, 8, 0, 2, 1, "R3 remap and clear ready");
    rename(11, 1, 1, 1, 9, "R3 second alloc");
    rename(12, 0, 0, 1, 0, "R4 no-dest accepted");
  endtask

  task automatic t_squash();
    walk(1, 10, 0, 0, 2, "R9 busy for one undo");
    lookup(1, 0, 8, 0, 0, 1, "R6 map restored");
  endtask

  task automatic t_commit();
    walk(0, 0, 1, 10, 2, "R9 busy for one retire");
    // free order now 10..15, 9, 1
    rename(20, 1, 0, 1, 10, "R3 fill");
    rename(21, 1, 1, 1, 11, "R3 fill");
    rename(22, 1, 2, 1, 12, "R3 fill");
    rename(23, 1, 3, 1, 13, "R3 fill");
    rename(24, 1, 4, 1, 14, "R3 fill");
    rename(25, 1, 5, 1, 15, "R3 fill");
    rename(26, 1, 6, 1, 9,  "R6 undone reg reused");
    rename(27, 1, 7, 1, 1,  "R7 released prev reused");
    rename(28, 1, 0, 0, 0,  "R4 refuse when empty");
    rename(28, 0, 0, 1, 0,  "R4 no-dest when empty");
    walk(0, 0, 1, 22, 4, "R9 busy for three retires");
    rename(30, 1, 3, 1, 0, "R7 prev of seq20");
    rename(31, 1, 3, 1, 8, "R7 prev of seq21");
    rename(32, 1, 3, 1, 2, "R7 prev of seq22");
    rename(33, 1, 3, 0, 0, "R7 only three freed");
    walk(0, 0, 1, 5, 1, "R8 oldest younger retires nothing");
    rename(33, 1, 3, 0, 0, "R8 nothing freed");
  endtask

  task automatic t_collide();
    walk(1, 29, 1, 200, 4, "R9 squash of three");
    lookup(3, 0, 13, 0, 10, 0, "R6 rollback to oldest prev");
    rename(40, 1, 6, 1, 2, "R6 tail order newest first");
    rename(41, 1, 6, 1, 8, "R6 tail order");
    rename(42, 1, 6, 1, 0, "R6 tail order");
    rename(43, 1, 6, 0, 0, "R8 commit ignored during squash");
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
          total++; bad++;
          $display("FAIL watchdog: actual=timeout expected=done");
          $display("test done: total=%0d bad=%0d", total, bad);
          $finish;
        end
      end
    join_none
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_basic();
    t_squash();
    t_commit();
    t_collide();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule